// File: doc/BRIEF.md
# Protected Page Memory Access Controller

This block guards host access to a small on-chip user store organised as pages. Every page carries five protection attributes: read lock, write lock, burn-once emulation, MAC-gated write and pad encryption. These attributes combine freely, and all active ones apply at the same time. The host issues one command per page. It sends a page number, a direction, a 256-bit host MAC and both one-time pads. Data then moves one byte per handshake over valid/ready streams, byte 0 first, and byte i of any 256-bit word is bits [8i+7:8i]. A MAC engine outside the block supplies the expected MAC and the pads. The block does no hashing.

On a write, the incoming bytes are unmasked with the write pad when the page is encrypted. The host MAC is then compared against the expected MAC, one byte per cycle, over the full width. At the end, the block either stores the page or leaves it untouched. A store on an emulation page can only clear bits. On a read, the page is masked with the read pad before it leaves the block, unless the page is read-locked, in which case no data is sent. A separate combinational port lets consumers inside the chip read any byte whatever its attributes. A one-cycle `done` pulse carries a two-bit result code.

Top module: `prot_mem_ctrl`

## Requirements
- R1: After reset, every page's attribute word is zero (no protection) and every stored byte is zero. Attribute bits are: bit0 read lock, bit1 write lock, bit2 emulation, bit3 MAC gate, bit4 encryption. They are loaded per page through `cfg_we`/`cfg_page`/`cfg_attr`.
- R2: The attributes of a page act together. When a write is refused for two reasons, write lock takes priority over a MAC mismatch and the result is code 1.
- R3: A read of a read-locked page presents no byte on `out_valid` and ends with code 3. The internal port `int_data` still shows the stored byte.
- R4: A write to a write-locked page leaves the page unchanged and ends with code 1, even when the host MAC matches.
- R5: On an emulation page, a committed write stores old AND new, so no bit goes from 0 to 1.
- R6: On a MAC-gated page, a write commits only when all 256 bits of `cmd_mac` equal `exp_mac`. Otherwise the page is unchanged and the result is code 2.
- R7: On an encrypted page, each write byte i is XORed with byte i of `wr_pad` before it is stored.
- R8: On an encrypted page, each read byte i is the stored byte XORed with byte i of `rd_pad`. The write pad is never used for a read and the read pad never for a write.
- R9: The MAC comparison always takes the same number of cycles, whatever the position of the first differing bit, or whether any bit differs at all.
- R10: Each command ends with `done` high for exactly one cycle, in the cycle after the store decision or the last read byte. `status` holds the code: 0 success, 1 write locked, 2 MAC mismatch, 3 read locked.
- R11: On a page that is both encrypted and MAC-gated, a matching MAC stores the unmasked data (ANDed with the old data if emulation is also set). A mismatching MAC stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load attribute word of `cfg_page` |
| cfg_page | input | 4 | Page whose attributes are loaded |
| cfg_attr | input | 5 | Attribute word (bit map in R1) |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle, command accepted when valid |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_page | input | 4 | Target page |
| cmd_mac | input | 256 | Host MAC for a write |
| wr_pad | input | 256 | Write pad, sampled at command accept |
| rd_pad | input | 256 | Read pad, sampled at command accept |
| exp_mac | input | 256 | Expected MAC, held stable during the compare |
| in_valid | input | 1 | Write byte valid |
| in_ready | output | 1 | Write byte accepted |
| in_data | input | 8 | Write byte |
| out_valid | output | 1 | Read byte valid |
| out_ready | input | 1 | Read byte taken |
| out_data | output | 8 | Read byte |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result code (R10) |
| int_page | input | 4 | Internal read page |
| int_byte | input | 5 | Internal read byte index |
| int_data | output | 8 | Internal read byte, unaffected by attributes |

## Verification
The bench sweeps all 32 attribute combinations, each with a matching and a mismatching host MAC, and reads every outcome back after clearing the attributes. A swapped pad, a lock priority inverted or an emulation merge written as OR would each show up as a wrong stored page or a wrong code. A MAC that differs only in its first byte, only in its top bit, or not at all must give the same write latency. An early-exit comparator would finish sooner on the first case, and a comparator that checks too few bytes would report success on the second. Read-locked pages are checked for silence on the data stream while the internal port still returns their contents.

// File: rtl/prot_pkg.sv
package prot_pkg;

   // bit0 rprot ... bit4 enc
   typedef struct packed {
      logic enc;
      logic auth;
      logic emu;
      logic wprot;
      logic rprot;
   } page_attr_t;

   localparam int ATTR_W = 5;

   typedef enum logic [1:0] {
      ST_OK     = 2'd0,
      ST_WPROT  = 2'd1,
      ST_BADMAC = 2'd2,
      ST_RPROT  = 2'd3
   } xfer_stat_t;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RECV,
      S_CMP,
      S_COMMIT,
      S_SEND,
      S_FIN
   } ctl_state_t;

endpackage

// File: rtl/pma_attr_tab.sv
module pma_attr_tab
   import prot_pkg::*;
#(
   parameter int PAGES = 16,
   localparam int PG_W = $clog2(PAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [PG_W-1:0]   cfg_page,
   input  logic [ATTR_W-1:0] cfg_attr,
   input  logic [PG_W-1:0]   look_page,
   output page_attr_t        look_attr
);

   logic [ATTR_W-1:0] tab_q [PAGES];

   for (genvar p = 0; p < PAGES; p++) begin : g_attr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tab_q[p] <= '0;
         else if (cfg_we && cfg_page == PG_W'(p))
            tab_q[p] <= cfg_attr;
      end
   end

   assign look_attr = page_attr_t'(tab_q[look_page]);

endmodule

// File: rtl/pma_mac_cmp.sv
module pma_mac_cmp #(
   parameter int MAC_W = 256,
   localparam int NB = MAC_W / 8,
   localparam int CW = $clog2(NB)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [MAC_W-1:0] a_mac,
   input  logic [MAC_W-1:0] b_mac,
   output logic             done,
   output logic             match
);

   logic [CW-1:0] idx_q;
   logic          busy_q;
   logic          diff_q;
   logic          done_q;
   logic          match_q;
   logic          byte_diff;

   assign byte_diff = |(a_mac[idx_q*8 +: 8] ^ b_mac[idx_q*8 +: 8]);

   // every byte is visited, no early exit on a difference
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         busy_q  <= 1'b0;
         diff_q  <= 1'b0;
         done_q  <= 1'b0;
         match_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            diff_q <= 1'b0;
         end else if (busy_q) begin
            diff_q <= diff_q | byte_diff;
            idx_q  <= idx_q + 1'b1;
            if (idx_q == CW'(NB - 1)) begin
               busy_q  <= 1'b0;
               done_q  <= 1'b1;
               match_q <= !(diff_q | byte_diff);
            end
         end
      end
   end

   assign done  = done_q;
   assign match = match_q;

   // R9
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q);

endmodule

// File: rtl/pma_page_store.sv
module pma_page_store #(
   parameter int PAGES = 16,
   parameter int PAGE_BYTES = 32,
   localparam int PG_W = $clog2(PAGES),
   localparam int PW = PAGE_BYTES * 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [PG_W-1:0] wr_page,
   input  logic            wr_emu,
   input  logic [PW-1:0]   wr_word,
   input  logic [PG_W-1:0] rd_page,
   output logic [PW-1:0]   rd_word,
   input  logic [PG_W-1:0] int_page,
   output logic [PW-1:0]   int_word
);

   logic [PW-1:0] mem_w [PAGES];

   for (genvar p = 0; p < PAGES; p++) begin : g_page
      logic [PW-1:0] word_q;
      logic          hit;

      assign hit = we && (wr_page == PG_W'(p));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (hit)
            word_q <= wr_emu ? (word_q & wr_word) : wr_word;
      end

      assign mem_w[p] = word_q;

      // R5
      em_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && wr_emu) |=> ((word_q & ~$past(word_q)) == '0));
   end

   assign rd_word  = mem_w[rd_page];
   assign int_word = mem_w[int_page];

endmodule

// File: rtl/prot_mem_ctrl.sv
module prot_mem_ctrl
   import prot_pkg::*;
#(
   parameter int PAGES = 16,
   parameter int PAGE_BYTES = 32,
   parameter int MAC_W = 256,
   localparam int PG_W = $clog2(PAGES),
   localparam int BI_W = $clog2(PAGE_BYTES),
   localparam int PW = PAGE_BYTES * 8,
   localparam int MAC_BYTES = MAC_W / 8,
   localparam int MC_W = $clog2(MAC_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [PG_W-1:0]   cfg_page,
   input  logic [ATTR_W-1:0] cfg_attr,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_write,
   input  logic [PG_W-1:0]   cmd_page,
   input  logic [MAC_W-1:0]  cmd_mac,
   input  logic [PW-1:0]     wr_pad,
   input  logic [PW-1:0]     rd_pad,
   input  logic [MAC_W-1:0]  exp_mac,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [7:0]        in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data,
   output logic              done,
   output logic [1:0]        status,
   input  logic [PG_W-1:0]   int_page,
   input  logic [BI_W-1:0]   int_byte,
   output logic [7:0]        int_data
);

   if (PAGES < 2) begin : g_bad_pages
      $error("PAGES must be at least 2");
   end
   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_bytes
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (MAC_W % 8 != 0 || MAC_W < 16) begin : g_bad_mac
      $error("MAC_W must be a whole number of bytes, at least 2");
   end

   ctl_state_t         state_q;
   logic [BI_W-1:0]    cnt_q;
   logic [PG_W-1:0]    page_q;
   page_attr_t         attr_q;
   page_attr_t         look_attr;
   logic [PW-1:0]      pad_q;
   logic [MAC_W-1:0]   hmac_q;
   logic [PW-1:0]      buf_q;
   xfer_stat_t         stat_q;
   logic [MC_W-1:0]    cmp_cyc_q;
   logic               last_byte;
   logic               cmp_start;
   logic               cmp_done;
   logic               cmp_match;
   logic               mem_we;
   logic [PW-1:0]      rd_word;
   logic [PW-1:0]      int_word;
   logic [7:0]         pad_byte;

   pma_attr_tab #(.PAGES(PAGES)) i_attr (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_page  (cfg_page),
      .cfg_attr  (cfg_attr),
      .look_page (cmd_page),
      .look_attr (look_attr)
   );

   pma_mac_cmp #(.MAC_W(MAC_W)) i_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .start (cmp_start),
      .a_mac (hmac_q),
      .b_mac (exp_mac),
      .done  (cmp_done),
      .match (cmp_match)
   );

   pma_page_store #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (mem_we),
      .wr_page  (page_q),
      .wr_emu   (attr_q.emu),
      .wr_word  (buf_q),
      .rd_page  (page_q),
      .rd_word  (rd_word),
      .int_page (int_page),
      .int_word (int_word)
   );

   assign last_byte = (cnt_q == BI_W'(PAGE_BYTES - 1));
   assign pad_byte  = attr_q.enc ? pad_q[cnt_q*8 +: 8] : 8'h00;
   assign cmp_start = (state_q == S_RECV) && in_valid && last_byte;
   assign mem_we    = (state_q == S_COMMIT) && !attr_q.wprot && (!attr_q.auth || cmp_match);

   assign cmd_ready = (state_q == S_IDLE);
   assign in_ready  = (state_q == S_RECV);
   assign out_valid = (state_q == S_SEND);
   assign out_data  = rd_word[cnt_q*8 +: 8] ^ pad_byte;
   assign done      = (state_q == S_FIN);
   assign status    = stat_q;
   assign int_data  = int_word[int_byte*8 +: 8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         cnt_q   <= '0;
         page_q  <= '0;
         attr_q  <= '0;
         pad_q   <= '0;
         hmac_q  <= '0;
         buf_q   <= '0;
         stat_q  <= ST_OK;
      end else begin
         case (state_q)
            S_IDLE: if (cmd_valid) begin
               page_q <= cmd_page;
               attr_q <= look_attr;
               hmac_q <= cmd_mac;
               pad_q  <= cmd_write ? wr_pad : rd_pad;
               cnt_q  <= '0;
               stat_q <= ST_OK;
               if (cmd_write)
                  state_q <= S_RECV;
               else if (look_attr.rprot) begin
                  stat_q  <= ST_RPROT;
                  state_q <= S_FIN;
               end else
                  state_q <= S_SEND;
            end
            S_RECV: if (in_valid) begin
               buf_q[cnt_q*8 +: 8] <= in_data ^ pad_byte;
               cnt_q <= cnt_q + 1'b1;
               if (last_byte)
                  state_q <= S_CMP;
            end
            S_CMP: if (cmp_done)
               state_q <= S_COMMIT;
            S_COMMIT: begin
               if (attr_q.wprot)
                  stat_q <= ST_WPROT;
               else if (attr_q.auth && !cmp_match)
                  stat_q <= ST_BADMAC;
               else
                  stat_q <= ST_OK;
               state_q <= S_FIN;
            end
            S_SEND: if (out_ready) begin
               cnt_q <= cnt_q + 1'b1;
               if (last_byte)
                  state_q <= S_FIN;
            end
            S_FIN: state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // independent count of cycles spent waiting on the comparator
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cmp_cyc_q <= '0;
      else if (state_q != S_CMP)
         cmp_cyc_q <= '0;
      else
         cmp_cyc_q <= cmp_cyc_q + 1'b1;
   end

   // R9
   cmp_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_done |-> (cmp_cyc_q == MC_W'(MAC_BYTES)));

   // R3
   rp_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !attr_q.rprot);

   // R4
   wp_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !attr_q.wprot);

   // R6
   ap_mac_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && attr_q.auth) |-> cmp_match);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/test_prot_mem_ctrl.sv
module test_prot_mem_ctrl;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [3:0]   cfg_page = '0;
   logic [4:0]   cfg_attr = '0;
   logic         cmd_valid = 1'b0;
   logic         cmd_ready;
   logic         cmd_write = 1'b0;
   logic [3:0]   cmd_page = '0;
   logic [255:0] cmd_mac = '0;
   logic [255:0] wr_pad = '0;
   logic [255:0] rd_pad = '0;
   logic [255:0] exp_mac = '0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [7:0]   in_data = '0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [7:0]   out_data;
   logic         done;
   logic [1:0]   status;
   logic [3:0]   int_page = '0;
   logic [4:0]   int_byte = '0;
   logic [7:0]   int_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   prot_mem_ctrl i_prot_mem_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_page(cfg_page), .cfg_attr(cfg_attr),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
      .cmd_page(cmd_page), .cmd_mac(cmd_mac), .wr_pad(wr_pad), .rd_pad(rd_pad),
      .exp_mac(exp_mac), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .done(done), .status(status),
      .int_page(int_page), .int_byte(int_byte), .int_data(int_data)
   );

   task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [255:0] mkv(input int s);
      logic [255:0] v;
      for (int i = 0; i < 32; i++)
         v[i*8 +: 8] = 8'((s * 73 + i * 29 + (s >> 3) * i) ^ (i << 2));
      return v;
   endfunction

   task automatic set_attr(input int pg, input logic [4:0] a);
      @(negedge clk);
      cfg_we = 1'b1; cfg_page = 4'(pg); cfg_attr = a;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run_write(input int pg, input logic [255:0] data, input logic [255:0] hmac,
                            input logic [255:0] emac, input logic [255:0] wpad,
                            output logic [1:0] st, output int lat);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = 1'b1; cmd_page = 4'(pg);
      cmd_mac = hmac; exp_mac = emac; wr_pad = wpad; rd_pad = ~wpad;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int i = 0; i < 32; i++) begin
         in_valid = 1'b1; in_data = data[i*8 +: 8];
         while (!in_ready) @(negedge clk);
         @(negedge clk);
      end
      in_valid = 1'b0;
      lat = 0;
      while (!done && lat < 500) begin
         @(negedge clk);
         lat++;
      end
      st = status;
   endtask

   task automatic run_read(input int pg, input logic [255:0] rpad,
                           output logic [255:0] data, output logic [1:0] st, output int nb);
      int guard;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = 1'b0; cmd_page = 4'(pg);
      rd_pad = rpad; wr_pad = ~rpad;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      nb = 0; data = '0; guard = 0;
      while (!done && guard < 500) begin
         if (out_valid) begin
            if (nb < 32) data[nb*8 +: 8] = out_data;
            nb++;
         end
         @(negedge clk);
         guard++;
      end
      st = status;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [255:0] d, oldv, newv, wpv, rpv, emv, expv, plain;
      logic [1:0]   st, est;
      int           lat, nb, lat_a, lat_b, lat_c;
      string        tag;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cmd_ready && !done && !out_valid && !in_ready, "R1 idle after reset", 256'(cmd_ready), 256'(1));
      run_read(5, mkv(9), d, st, nb);
      chk(st == 2'd0 && nb == 32, "R1 page unprotected after reset", 256'(st), 256'(0));
      chk(d == '0, "R1 page zero after reset", d, '0);

      // sweep every attribute combination, MAC matching and not
      for (int f = 0; f < 32; f++) begin
         for (int mm = 0; mm < 2; mm++) begin
            int pg;
            pg   = (f + mm * 7) % 16;
            oldv = mkv(f * 4 + mm + 1);
            newv = mkv(f * 4 + mm + 100);
            wpv  = mkv(f + 300);
            rpv  = mkv(f + 400);
            emv  = mkv(f * 2 + mm + 500);

            set_attr(pg, 5'd0);
            run_write(pg, oldv, '0, '0, '0, st, lat);
            chk(st == 2'd0, "R10 plain write status", 256'(st), 256'(0));

            set_attr(pg, 5'(f));
            run_write(pg, newv, mm != 0 ? (emv ^ 256'd1) : emv, emv, wpv, st, lat);
            if (f[1]) begin
               est = 2'd1; expv = oldv; tag = "R4";
            end else if (f[3] && mm != 0) begin
               est = 2'd2; expv = oldv; tag = f[4] ? "R11" : "R6";
            end else begin
               est = 2'd0;
               plain = f[4] ? (newv ^ wpv) : newv;
               expv = f[2] ? (oldv & plain) : plain;
               tag = (f[4] && f[3]) ? "R11" : f[4] ? "R7" : f[2] ? "R5" : f[3] ? "R6" : "R10";
            end
            chk(st == est, {tag, " write status"}, 256'(st), 256'(est));
            if (f[1] && f[3] && mm != 0)
               chk(st == 2'd1, "R2 write lock outranks mac mismatch", 256'(st), 256'(1));

            run_read(pg, rpv, d, st, nb);
            if (f[0]) begin
               chk(st == 2'd3 && nb == 0, "R3 locked read silent", 256'(nb), 256'(0));
            end else begin
               chk(st == 2'd0 && nb == 32, "R10 read status and length", 256'(nb), 256'(32));
               chk(d == (f[4] ? (expv ^ rpv) : expv), "R8 read data", d, f[4] ? (expv ^ rpv) : expv);
            end

            for (int i = 0; i < 32; i += 5) begin
               int_page = 4'(pg); int_byte = 5'(i);
               #1;
               chk(int_data == expv[i*8 +: 8], "R3 internal port", 256'(int_data), 256'(expv[i*8 +: 8]));
            end

            set_attr(pg, 5'd0);
            run_read(pg, rpv, d, st, nb);
            chk(d == expv, {tag, " stored page"}, d, expv);
         end
      end

      // R9 compare time independent of mismatch position
      set_attr(3, 5'b01000);
      emv = mkv(777);
      run_write(3, mkv(1), emv ^ 256'hFF, emv, '0, st, lat_a);
      chk(st == 2'd2, "R9 first byte mismatch", 256'(st), 256'(2));
      run_write(3, mkv(2), emv ^ {1'b1, 255'd0}, emv, '0, st, lat_b);
      chk(st == 2'd2, "R9 top bit mismatch caught", 256'(st), 256'(2));
      run_write(3, mkv(3), emv, emv, '0, st, lat_c);
      chk(st == 2'd0, "R9 full match", 256'(st), 256'(0));
      chk(lat_a == lat_b && lat_b == lat_c, "R9 equal latency", 256'(lat_a), 256'(lat_c));

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule